// File: doc/BRIEF.md
# Dual-Port Link Failover Controller

This block decides which of two network ports carries management traffic. It watches the link-up status of a primary and a secondary port. When the primary link has been down without a break for a programmed number of seconds, and the secondary link is up, the block moves traffic to the secondary port. When the primary link then stays up without a break for the same programmed number of seconds, the block moves traffic back. Each change of port produces a one-cycle event pulse and an immediate request to send a gratuitous ARP on the new port.

The block also asks for gratuitous ARP transmissions at regular times, at an interval given in seconds. A value of zero turns these periodic requests off. Time is measured with a one-cycle `sec_tick` pulse that the surrounding logic supplies once per second. Building the ARP frame and sending it belong to other blocks.

Top module: `link_failover_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block selects the primary port (`use_secondary` = 0), drives `switch_pulse` and `arp_req` low, and clears both of its second counters.
- R2: `use_secondary` is 0 for the primary port and 1 for the secondary port. In the primary state, each `sec_tick` pulse seen while `pri_link_up` is low adds one second. `use_secondary` becomes 1 at the first clock edge at which the count has reached `failover_secs` and `sec_link_up` is high. That edge is the one that follows the edge taking the final tick. With `failover_secs` = 0, the switch happens at the first edge with the primary link down.
- R3: In the secondary state, the same rule applies with `pri_link_up` high. `use_secondary` returns to 0 once the primary link has been up for `failover_secs` ticks, whatever the state of the secondary link.
- R4: A single cycle in which the primary link leaves the qualifying level sets the down count or the up count back to zero.
- R5: While `sec_link_up` is low, the block stays on the primary port. If the primary link is still down and already qualified when `sec_link_up` rises, the switch happens at the next clock edge.
- R6: `switch_pulse` is high for exactly one cycle: the first cycle in which `use_secondary` shows its new value. It is never high at any other time.
- R7: `arp_req` is high in every cycle in which `switch_pulse` is high.
- R8: When `arp_secs` = A is non-zero, `arp_req` goes high for one cycle right after the edge that takes the A-th `sec_tick` since the last reset, switch or ARP request.
- R9: When `arp_secs` is zero, `arp_req` goes high only together with `switch_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pri_link_up | input | 1 | Link status of the primary port, 1 = up |
| sec_link_up | input | 1 | Link status of the secondary port, 1 = up |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| failover_secs | input | SEC_W | Seconds needed to qualify a down or up state |
| arp_secs | input | SEC_W | Seconds between gratuitous ARP requests, 0 = off |
| use_secondary | output | 1 | Active port: 0 = primary, 1 = secondary |
| switch_pulse | output | 1 | One-cycle pulse on each change of active port |
| arp_req | output | 1 | One-cycle request to send a gratuitous ARP |

## Verification
The fail-over time is swept from zero to four seconds. For each value the bench drops the primary link, later restores it, and checks the exact edge of each switch. This separates an off-by-one in the qualification count from a wrong latency. A one-cycle glitch in each direction shows whether the counter restarts or only pauses. Holding the secondary link down separates a blocked switch from one that is merely late. The ARP interval is swept from zero to four while ticks arrive at a fixed spacing, and every cycle is compared with the arithmetic prediction. This exposes wrong periods, a missing restart after a request, and requests that should have been disabled.

// File: rtl/lfo_pkg.sv
// Shared types for the link failover controller.
package lfo_pkg;
    // Active-port encoding; the numeric value is the use_secondary output.
    typedef enum logic {
        PORT_PRI = 1'b0,
        PORT_SEC = 1'b1
    } port_sel_e;
endpackage

// File: rtl/lfo_qual_timer.sv
// Qualification timer.
// Counts second ticks while `qualify` is high. The count is cleared in any
// cycle where `qualify` is low, or where `restart` is high. The count
// saturates at its maximum value. `met` is high while `qualify` holds and
// the count has reached `limit`.
// Assumes: `tick` is a one-cycle pulse; `limit` may change at any time.
module lfo_qual_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qualify,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             met
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Count qualifying seconds; any break or restart clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !qualify) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The condition is qualified once enough seconds have gone by.
    always_comb begin
        met = qualify && (cnt_q >= limit);
    end
endmodule

// File: rtl/lfo_port_select.sv
// Port selector.
// Holds the active port. It tells the timer which primary-link level
// qualifies in the current state, and moves to the other port when the timer
// reports qualification. A fail-over also needs the secondary link to be up;
// a fail-back does not. On each change it raises a one-cycle pulse that
// lines up with the new selection.
// Assumes: `met` comes from a timer driven by `qualify`.
module lfo_port_select
    import lfo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pri_up,
    input  logic      sec_up,
    input  logic      met,
    output logic      qualify,
    output logic      switch_now,
    output port_sel_e sel,
    output logic      switch_pulse
);
    // Choose the qualifying level and decide whether to switch this cycle.
    always_comb begin
        if (sel == PORT_PRI) begin
            qualify    = !pri_up;
            switch_now = met && sec_up;
        end else begin
            qualify    = pri_up;
            switch_now = met;
        end
    end

    // Register the active port and the change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel          <= PORT_PRI;
            switch_pulse <= 1'b0;
        end else begin
            switch_pulse <= switch_now;
            if (switch_now) begin
                sel <= (sel == PORT_PRI) ? PORT_SEC : PORT_PRI;
            end
        end
    end
endmodule

// File: rtl/lfo_arp_timer.sv
// Gratuitous ARP scheduler.
// Raises a one-cycle request right after each port switch. It also raises a
// request after `interval` second ticks since the last request, switch or
// reset. An interval of zero disables the periodic requests.
// Assumes: `tick` is a one-cycle pulse; `restart` marks the switch decision.
module lfo_arp_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] interval,
    output logic             req
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_next;
    logic             enabled;
    logic             due;

    // Work out whether this tick completes the interval.
    always_comb begin
        enabled  = (interval != '0);
        cnt_next = {1'b0, cnt_q} + 1'b1;
        due      = tick && enabled && (cnt_next >= {1'b0, interval});
    end

    // Count ticks toward the next request and register the request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            req   <= 1'b0;
        end else if (restart || due) begin
            cnt_q <= '0;
            req   <= 1'b1;
        end else begin
            req <= 1'b0;
            if (tick && enabled) begin
                cnt_q <= cnt_next[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/link_failover_ctrl.sv
// Dual-port link failover controller, top level.
// Links the qualification timer, the port selector and the ARP scheduler.
// Every output is registered. A switch decided in one cycle appears on
// use_secondary, switch_pulse and arp_req in the next cycle.
// Assumes: sec_tick is a one-cycle pulse once per second, synchronous to clk,
// and the link-status inputs are already synchronised.
module link_failover_ctrl
    import lfo_pkg::*;
#(
    parameter int SEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pri_link_up,
    input  logic             sec_link_up,
    input  logic             sec_tick,
    input  logic [SEC_W-1:0] failover_secs,
    input  logic [SEC_W-1:0] arp_secs,
    output logic             use_secondary,
    output logic             switch_pulse,
    output logic             arp_req
);
    logic      qualify;
    logic      met;
    logic      switch_now;
    port_sel_e sel;

    lfo_qual_timer #(.CNT_W(SEC_W)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .qualify (qualify),
        .restart (switch_now),
        .tick    (sec_tick),
        .limit   (failover_secs),
        .met     (met)
    );

    lfo_port_select u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .pri_up       (pri_link_up),
        .sec_up       (sec_link_up),
        .met          (met),
        .qualify      (qualify),
        .switch_now   (switch_now),
        .sel          (sel),
        .switch_pulse (switch_pulse)
    );

    lfo_arp_timer #(.CNT_W(SEC_W)) u_arp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .restart  (switch_now),
        .interval (arp_secs),
        .req      (arp_req)
    );

    // Map the selected port onto the output bit.
    always_comb begin
        use_secondary = (sel == PORT_SEC);
    end
endmodule

// File: rtl/lfo_checker.sv
// Port-level properties of the failover controller, bound to the top module.
// Assumes: the environment asserts rst_n at least once before relying on
// the outputs.
module lfo_checker #(
    parameter int SEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pri_link_up,
    input logic             sec_link_up,
    input logic [SEC_W-1:0] arp_secs,
    input logic             use_secondary,
    input logic             switch_pulse,
    input logic             arp_req
);
    logic started = 1'b0;
    logic seen_rst = 1'b0;
    logic past_ok = 1'b0;

    // Track whether history since reset is long enough to look one cycle back.
    always_ff @(posedge clk) begin
        started  <= 1'b1;
        seen_rst <= seen_rst || !rst_n;
        past_ok  <= rst_n && seen_rst;
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!started)
        !$past(rst_n) |-> (!use_secondary && !switch_pulse && !arp_req));

    p_hold_pri_link_up_r2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!$past(use_secondary) && $past(pri_link_up)) |-> !use_secondary);

    p_hold_sec_link_down_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(use_secondary) && !$past(pri_link_up)) |-> use_secondary);

    p_hold_pri_sec_down_r5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!$past(use_secondary) && !$past(sec_link_up)) |-> !use_secondary);

    p_pulse_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        switch_pulse == (use_secondary != $past(use_secondary)));

    p_arp_on_switch_r7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        switch_pulse |-> arp_req);

    p_quiet_arp_r9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (($past(arp_secs) == '0) && !switch_pulse) |-> !arp_req);
endmodule

bind link_failover_ctrl lfo_checker #(.SEC_W(SEC_W)) u_lfo_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .pri_link_up   (pri_link_up),
    .sec_link_up   (sec_link_up),
    .arp_secs      (arp_secs),
    .use_secondary (use_secondary),
    .switch_pulse  (switch_pulse),
    .arp_req       (arp_req)
);

// File: tb/tb_link_failover_ctrl.sv
`timescale 1ns/100ps
// Bench: sweeps the fail-over time and the ARP interval over small values.
// Expected edges are computed from the tick spacing (one tick every 4 cycles).
module tb_link_failover_ctrl;
    localparam int SEC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pri = 1'b1;
    logic             sec = 1'b1;
    logic             tick = 1'b0;
    logic [SEC_W-1:0] fsecs = '0;
    logic [SEC_W-1:0] asecs = '0;
    logic             use_secondary;
    logic             switch_pulse;
    logic             arp_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    link_failover_ctrl #(.SEC_W(SEC_W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pri_link_up   (pri),
        .sec_link_up   (sec),
        .sec_tick      (tick),
        .failover_secs (fsecs),
        .arp_secs      (asecs),
        .use_secondary (use_secondary),
        .switch_pulse  (switch_pulse),
        .arp_req       (arp_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One rising edge; returns at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    // Ticks at cycle index 3, 7, 11... The switch to `want` is expected at edge 4*F.
    task automatic run_switch(input int f, input bit want, input string req);
        int seen_at = -1;
        for (int j = 0; j < 4 * f + 12; j++) begin
            tick = (j % 4 == 3);
            step();
            if (use_secondary == want) begin
                seen_at = j;
                chk(switch_pulse == 1'b1, "R6", switch_pulse, 1);
                chk(arp_req == 1'b1, "R7", arp_req, 1);
                break;
            end
        end
        tick = 1'b0;
        chk(seen_at == 4 * f, req, seen_at, 4 * f);
        step();
        chk(switch_pulse == 1'b0, "R6 one cycle", switch_pulse, 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk(use_secondary == 1'b0, "R1 select", use_secondary, 0);
        chk(switch_pulse == 1'b0, "R1 pulse", switch_pulse, 0);
        chk(arp_req == 1'b0, "R1 arp", arp_req, 0);

        // R2/R3 sweep over the fail-over time.
        for (int f = 0; f <= 4; f++) begin
            asecs = '0;
            fsecs = SEC_W'(f);
            pri = 1'b1;
            sec = 1'b1;
            do_reset();
            step();
            pri = 1'b0;
            run_switch(f, 1'b1, "R2 failover edge");
            step();
            pri = 1'b1;
            run_switch(f, 1'b0, "R3 failback edge");
        end

        // R3: fail-back ignores the secondary link.
        fsecs = 8'd1;
        do_reset();
        pri = 1'b0;
        run_switch(1, 1'b1, "R2 failover edge");
        sec = 1'b0;
        pri = 1'b1;
        run_switch(1, 1'b0, "R3 failback with secondary down");
        sec = 1'b1;

        // R4: a glitch in the down count, then a glitch in the up count.
        fsecs = 8'd3;
        do_reset();
        pri = 1'b0;
        for (int j = 0; j < 8; j++) begin
            tick = (j % 4 == 3);
            step();
        end
        tick = 1'b0;
        chk(use_secondary == 1'b0, "R4 before glitch", use_secondary, 0);
        pri = 1'b1;
        step();
        pri = 1'b0;
        run_switch(3, 1'b1, "R4 down count restarted");
        pri = 1'b1;
        for (int j = 0; j < 8; j++) begin
            tick = (j % 4 == 3);
            step();
        end
        tick = 1'b0;
        pri = 1'b0;
        step();
        pri = 1'b1;
        run_switch(3, 1'b0, "R4 up count restarted");

        // R5: secondary down blocks the fail-over; recovery switches at once.
        fsecs = 8'd1;
        do_reset();
        sec = 1'b0;
        pri = 1'b0;
        for (int j = 0; j < 20; j++) begin
            tick = (j % 4 == 3);
            step();
            chk(use_secondary == 1'b0 && switch_pulse == 1'b0, "R5 blocked",
                use_secondary, 0);
        end
        tick = 1'b0;
        sec = 1'b1;
        step();
        chk(use_secondary == 1'b1, "R5 switch at next edge", use_secondary, 1);
        chk(switch_pulse == 1'b1, "R6 pulse", switch_pulse, 1);

        // R1: reset in the secondary state returns to the primary port.
        rst_n = 1'b0;
        step();
        chk(use_secondary == 1'b0, "R1 reset from secondary", use_secondary, 0);
        rst_n = 1'b1;

        // R8/R9 sweep over the ARP interval with both links up.
        pri = 1'b1;
        sec = 1'b1;
        fsecs = 8'd2;
        for (int a = 0; a <= 4; a++) begin
            int ticks = 0;
            asecs = SEC_W'(a);
            do_reset();
            for (int j = 0; j < 40; j++) begin
                bit exp_req;
                tick = (j % 4 == 3);
                if (tick) ticks++;
                step();
                exp_req = (a != 0) && tick && (ticks % a == 0);
                chk(arp_req == exp_req, (a == 0) ? "R9 disabled" : "R8 periodic",
                    arp_req, exp_req);
            end
            tick = 1'b0;
        end

        // R8: the periodic count restarts after a switch request.
        asecs = 8'd3;
        fsecs = 8'd1;
        do_reset();
        pri = 1'b0;
        run_switch(1, 1'b1, "R2 failover edge");
        begin
            int ticks = 0;
            for (int j = 0; j < 24; j++) begin
                bit exp_req;
                tick = (j % 4 == 3);
                if (tick) ticks++;
                step();
                exp_req = tick && (ticks % 3 == 0);
                chk(arp_req == exp_req, "R8 after switch", arp_req, exp_req);
            end
        end
        tick = 1'b0;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule